// File: doc/BRIEF.md
# Condition Register Update Unit

This block owns the condition register of a 32-bit integer core and applies every operation that rewrites it. The register is 32 bits wide and is split into eight 4-bit fields. Field numbering runs from the top: field 0 is the most significant nibble. Individual bits are also numbered from the top, so bit index 0 names register bit 31.

One operation is presented per cycle, together with a valid strobe. The operation code selects one of four kinds of work:
- a compare of two operands, or of an operand against a 16-bit immediate, with the outcome written into one field;
- a masked move of a general-register value into any chosen set of fields;
- a copy of one field into another;
- one of eight two-input boolean functions on single condition bits.

The current summary-overflow flag comes in as a plain input, and each compare copies it into the field it writes. A combinational read port returns any one field of the current register. The whole register is also visible on its own output.

Top module: `cr_update_unit`

## Requirements
- R1: After reset the register reads zero, on the full output and on every field of the read port.
- R2: The register keeps its value when valid_i is low, whatever the other inputs carry. It also keeps its value when valid_i is high and op_i is 0 (idle) or 7 (reserved).
- R3: Field n occupies register bits 31-4n down to 28-4n. The read port returns the field selected by rd_idx_i from the current register, in the same cycle.
- R4: A compare writes the field {LT, GT, EQ, SO}, with LT in bit 3 (value 8), GT in bit 2 (value 4), EQ in bit 1 (value 2) and so_i in bit 0 (value 1). Exactly one of LT, GT and EQ is set.
- R5: op_i = 1 compares opa_i with opb_i as signed 32-bit numbers and writes the field selected by dst_idx_i.
- R6: op_i = 2 compares opa_i with opb_i as unsigned 32-bit numbers and writes the field selected by dst_idx_i.
- R7: op_i = 3 compares signed opa_i against opb_i[15:0] sign-extended to 32 bits. opb_i[31:16] has no effect.
- R8: op_i = 4 compares unsigned opa_i against opb_i[15:0] zero-extended to 32 bits. opb_i[31:16] has no effect.
- R9: A compare or a field copy changes no field other than the one selected by dst_idx_i.
- R10: op_i = 5 is the masked move. Bit i of fmask_i selects register bits 4i+3 down to 4i, so fmask_i bit 7 selects field 0. Selected bits take the value of opa_i and all other bits keep their old value.
- R11: op_i = 6 copies field src_idx_i into field dst_idx_i.
- R12: op_i = 8 to 15 read register bits 31-bit_a_i and 31-bit_b_i and write the result to bit 31-bit_t_i. The functions are 8 AND, 9 OR, 10 NAND, 11 XOR, 12 NOR, 13 equivalence, 14 a AND NOT b, and 15 a OR NOT b.
- R13: A single-bit operation changes no register bit other than bit 31-bit_t_i.
- R14: Every update takes effect at the rising clock edge where valid_i is high, and appears on cr_o after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset that clears the register |
| valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 4 | Operation code (see R2, R5 to R12) |
| opa_i | input | 32 | First operand; also the source value of the masked move |
| opb_i | input | 32 | Second operand; the immediate sits in the low 16 bits |
| dst_idx_i | input | 3 | Destination field for compares and field copy |
| src_idx_i | input | 3 | Source field for field copy |
| bit_t_i | input | 5 | Target bit index for single-bit operations |
| bit_a_i | input | 5 | First source bit index |
| bit_b_i | input | 5 | Second source bit index |
| fmask_i | input | 8 | Field mask for the masked move |
| so_i | input | 1 | Current summary-overflow flag |
| rd_idx_i | input | 3 | Field selected for the read port |
| rd_field_o | output | 4 | Selected field of the current register |
| cr_o | output | 32 | Full current register value |

## Verification
The cases that are hardest to reach from the ports are the bit operations in which the target bit is also one of the source bits. Their result depends on register contents that only earlier operations can set up.

The bench therefore first loads a varied pattern through the masked move. It then runs every function over all 32 target positions, with source indices that sometimes coincide with the target. The running register value makes each operation's inputs depend on what came before.

The signed and unsigned immediate compares are driven with deliberate noise in opb_i[31:16], at values on both sides of the 0x8000 sign boundary. This separates the sign-extension path from the zero-extension path.

// File: rtl/cr_unit_pkg.sv
package cr_unit_pkg;

    typedef enum logic [3:0] {
        CR_IDLE     = 4'd0,
        CR_CMP_SREG = 4'd1,
        CR_CMP_UREG = 4'd2,
        CR_CMP_SIMM = 4'd3,
        CR_CMP_UIMM = 4'd4,
        CR_MOVE_MSK = 4'd5,
        CR_FLD_COPY = 4'd6,
        CR_RSVD     = 4'd7,
        CR_B_AND    = 4'd8,
        CR_B_OR     = 4'd9,
        CR_B_NAND   = 4'd10,
        CR_B_XOR    = 4'd11,
        CR_B_NOR    = 4'd12,
        CR_B_EQV    = 4'd13,
        CR_B_ANDC   = 4'd14,
        CR_B_ORC    = 4'd15
    } cr_op_e;

    // Bit positions inside a compare result field
    localparam int unsigned FLD_LT = 3;
    localparam int unsigned FLD_GT = 2;
    localparam int unsigned FLD_EQ = 1;
    localparam int unsigned FLD_SO = 0;

endpackage

// File: rtl/cr_cmp_field.sv
module cr_cmp_field #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned IMMW = 16,
    parameter int unsigned FW   = 4
) (
    input  logic            is_signed,
    input  logic            use_imm,
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    input  logic            so,
    output logic [FW-1:0]   fld
);
    import cr_unit_pkg::*;

    localparam int unsigned EXTW = XLEN - IMMW;

    logic [XLEN-1:0] rhs_ext;
    logic            lt;
    logic            gt;
    logic            eq;

    always_comb begin
        if (!use_imm) begin
            rhs_ext = rhs;
        end else if (is_signed) begin
            rhs_ext = {{EXTW{rhs[IMMW-1]}}, rhs[IMMW-1:0]};
        end else begin
            rhs_ext = {{EXTW{1'b0}}, rhs[IMMW-1:0]};
        end

        eq = (lhs == rhs_ext);
        if (is_signed) begin
            lt = ($signed(lhs) < $signed(rhs_ext));
        end else begin
            lt = (lhs < rhs_ext);
        end
        gt = !lt && !eq;

        fld         = '0;
        fld[FLD_LT] = lt;
        fld[FLD_GT] = gt;
        fld[FLD_EQ] = eq;
        fld[FLD_SO] = so;
    end
endmodule

// File: rtl/cr_mask_expand.sv
module cr_mask_expand #(
    parameter int unsigned NF = 8,
    parameter int unsigned FW = 4
) (
    input  logic [NF-1:0]    sel,
    output logic [NF*FW-1:0] mask
);
    for (genvar gi = 0; gi < NF; gi++) begin : g_nib
        assign mask[gi*FW +: FW] = {FW{sel[gi]}};
    end
endmodule

// File: rtl/cr_bit_logic.sv
module cr_bit_logic (
    input  logic [2:0] fn,
    input  logic       a,
    input  logic       b,
    output logic       y
);
    always_comb begin
        case (fn)
            3'd0:    y = a & b;
            3'd1:    y = a | b;
            3'd2:    y = ~(a & b);
            3'd3:    y = a ^ b;
            3'd4:    y = ~(a | b);
            3'd5:    y = ~(a ^ b);
            3'd6:    y = a & ~b;
            default: y = a | ~b;
        endcase
    end
endmodule

// File: rtl/cr_update_unit.sv
module cr_update_unit #(
    parameter int unsigned NF   = 8,
    parameter int unsigned FW   = 4,
    parameter int unsigned XLEN = 32,
    parameter int unsigned IMMW = 16,
    localparam int unsigned CRW = NF * FW,
    localparam int unsigned IW  = $clog2(NF),
    localparam int unsigned BW  = $clog2(CRW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [3:0]      op_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    input  logic [IW-1:0]   dst_idx_i,
    input  logic [IW-1:0]   src_idx_i,
    input  logic [BW-1:0]   bit_t_i,
    input  logic [BW-1:0]   bit_a_i,
    input  logic [BW-1:0]   bit_b_i,
    input  logic [NF-1:0]   fmask_i,
    input  logic            so_i,
    input  logic [IW-1:0]   rd_idx_i,
    output logic [FW-1:0]   rd_field_o,
    output logic [CRW-1:0]  cr_o
);
    import cr_unit_pkg::*;

    typedef struct packed {
        logic [CRW-1:0] cr;
    } cr_state_t;

    cr_state_t st_d;
    cr_state_t st_q;
    cr_op_e    op;

    logic           cmp_signed;
    logic           cmp_imm;
    logic [FW-1:0]  cmp_fld;
    logic [CRW-1:0] move_mask;
    logic           bit_a;
    logic           bit_b;
    logic           bit_y;

    // Field 0 is the most significant nibble.
    function automatic int unsigned fld_lsb(input logic [IW-1:0] n);
        return (NF - 1 - int'(n)) * FW;
    endfunction

    // Bit index 0 is the most significant register bit.
    function automatic int unsigned bit_pos(input logic [BW-1:0] n);
        return CRW - 1 - int'(n);
    endfunction

    assign op         = cr_op_e'(op_i);
    assign cmp_signed = (op == CR_CMP_SREG) || (op == CR_CMP_SIMM);
    assign cmp_imm    = (op == CR_CMP_SIMM) || (op == CR_CMP_UIMM);
    assign bit_a      = st_q.cr[bit_pos(bit_a_i)];
    assign bit_b      = st_q.cr[bit_pos(bit_b_i)];

    cr_cmp_field #(
        .XLEN (XLEN),
        .IMMW (IMMW),
        .FW   (FW)
    ) u_cmp (
        .is_signed (cmp_signed),
        .use_imm   (cmp_imm),
        .lhs       (opa_i),
        .rhs       (opb_i),
        .so        (so_i),
        .fld       (cmp_fld)
    );

    cr_mask_expand #(
        .NF (NF),
        .FW (FW)
    ) u_mask (
        .sel  (fmask_i),
        .mask (move_mask)
    );

    cr_bit_logic u_bitop (
        .fn (op_i[2:0]),
        .a  (bit_a),
        .b  (bit_b),
        .y  (bit_y)
    );

    always_comb begin
        st_d = st_q;
        if (valid_i) begin
            case (op)
                CR_CMP_SREG, CR_CMP_UREG, CR_CMP_SIMM, CR_CMP_UIMM: begin
                    st_d.cr[fld_lsb(dst_idx_i) +: FW] = cmp_fld;
                end
                CR_MOVE_MSK: begin
                    st_d.cr = (opa_i[CRW-1:0] & move_mask) | (st_q.cr & ~move_mask);
                end
                CR_FLD_COPY: begin
                    st_d.cr[fld_lsb(dst_idx_i) +: FW] = st_q.cr[fld_lsb(src_idx_i) +: FW];
                end
                CR_B_AND, CR_B_OR, CR_B_NAND, CR_B_XOR,
                CR_B_NOR, CR_B_EQV, CR_B_ANDC, CR_B_ORC: begin
                    st_d.cr[bit_pos(bit_t_i)] = bit_y;
                end
                default: begin
                    st_d = st_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cr_o       = st_q.cr;
    assign rd_field_o = st_q.cr[fld_lsb(rd_idx_i) +: FW];

endmodule

// File: rtl/cr_update_unit_chk.sv
module cr_update_unit_chk #(
    parameter int unsigned NF  = 8,
    parameter int unsigned FW  = 4,
    parameter int unsigned IW  = 3,
    parameter int unsigned BW  = 5,
    parameter int unsigned CRW = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           valid_i,
    input logic [3:0]     op_i,
    input logic [IW-1:0]  dst_idx_i,
    input logic [IW-1:0]  src_idx_i,
    input logic           so_i,
    input logic [CRW-1:0] cr_o
);
    function automatic logic [FW-1:0] field_of(input logic [CRW-1:0] v, input logic [IW-1:0] n);
        return FW'(v >> ((NF - 1 - int'(n)) * FW));
    endfunction

    logic is_cmp;
    logic is_bit;
    assign is_cmp = (op_i >= 4'd1) && (op_i <= 4'd4);
    assign is_bit = op_i[3];

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i || op_i == 4'd0 || op_i == 4'd7) |=> $stable(cr_o));

    // R4
    cmp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_cmp) |=> $countones(field_of(cr_o, $past(dst_idx_i)) & 4'b1110) == 1);

    // R4
    cmp_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_cmp) |=> field_of(cr_o, $past(dst_idx_i))[0] == $past(so_i));

    // R11
    fld_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd6) |=>
            field_of(cr_o, $past(dst_idx_i)) == field_of($past(cr_o), $past(src_idx_i)));

    // R13
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_bit) |=> $countones(cr_o ^ $past(cr_o)) <= 1);
endmodule

bind cr_update_unit cr_update_unit_chk #(
    .NF  (NF),
    .FW  (FW),
    .IW  (IW),
    .BW  (BW),
    .CRW (CRW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .dst_idx_i (dst_idx_i),
    .src_idx_i (src_idx_i),
    .so_i      (so_i),
    .cr_o      (cr_o)
);

// File: tb/test_cr_update_unit.sv
module test_cr_update_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [2:0]  dst_idx_i = '0;
    logic [2:0]  src_idx_i = '0;
    logic [4:0]  bit_t_i = '0;
    logic [4:0]  bit_a_i = '0;
    logic [4:0]  bit_b_i = '0;
    logic [7:0]  fmask_i = '0;
    logic        so_i = 1'b0;
    logic [2:0]  rd_idx_i = '0;
    logic [3:0]  rd_field_o;
    logic [31:0] cr_o;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_cr = '0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    cr_update_unit i_cr_update_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (valid_i),
        .op_i       (op_i),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .dst_idx_i  (dst_idx_i),
        .src_idx_i  (src_idx_i),
        .bit_t_i    (bit_t_i),
        .bit_a_i    (bit_a_i),
        .bit_b_i    (bit_b_i),
        .fmask_i    (fmask_i),
        .so_i       (so_i),
        .rd_idx_i   (rd_idx_i),
        .rd_field_o (rd_field_o),
        .cr_o       (cr_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [31:0] cr, input int op,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input int dst, input int src,
                                          input int t, input int ba, input int bb,
                                          input logic [7:0] m, input logic so);
        logic [31:0] r;
        logic [31:0] bx;
        logic [31:0] mk;
        logic        lt, gt, eq, x, y, v;
        bit          sgn;
        r = cr;
        if (op >= 1 && op <= 4) begin
            bx  = (op == 3) ? {{16{b[15]}}, b[15:0]} :
                  (op == 4) ? {16'h0, b[15:0]} : b;
            sgn = (op == 1) || (op == 3);
            lt  = sgn ? ($signed(a) < $signed(bx)) : (a < bx);
            gt  = sgn ? ($signed(a) > $signed(bx)) : (a > bx);
            eq  = (a == bx);
            r[28-4*dst +: 4] = {lt, gt, eq, so};
        end else if (op == 5) begin
            mk = '0;
            for (int i = 0; i < 8; i++) mk[4*i +: 4] = {4{m[i]}};
            r = (a & mk) | (cr & ~mk);
        end else if (op == 6) begin
            r[28-4*dst +: 4] = cr[28-4*src +: 4];
        end else if (op >= 8) begin
            x = cr[31-ba];
            y = cr[31-bb];
            case (op)
                8:  v = x & y;
                9:  v = x | y;
                10: v = !(x & y);
                11: v = x ^ y;
                12: v = !(x | y);
                13: v = (x == y);
                14: v = x & !y;
                default: v = x | !y;
            endcase
            r[31-t] = v;
        end
        return r;
    endfunction

    task automatic do_op(input string req, input int op, input logic [31:0] a,
                         input logic [31:0] b, input int dst, input int src,
                         input int t, input int ba, input int bb,
                         input logic [7:0] m, input logic so);
        @(negedge clk);
        valid_i   = 1'b1;
        op_i      = 4'(op);
        opa_i     = a;
        opb_i     = b;
        dst_idx_i = 3'(dst);
        src_idx_i = 3'(src);
        bit_t_i   = 5'(t);
        bit_a_i   = 5'(ba);
        bit_b_i   = 5'(bb);
        fmask_i   = m;
        so_i      = so;
        exp_cr    = model(exp_cr, op, a, b, dst, src, t, ba, bb, m, so);
        @(negedge clk);
        valid_i = 1'b0;
        check(req, cr_o, exp_cr);
    endtask

    task automatic check_read_port(input string req);
        for (int r = 0; r < 8; r++) begin
            rd_idx_i = 3'(r);
            #1;
            check(req, {28'h0, rd_field_o}, {28'h0, exp_cr[28-4*r +: 4]});
        end
    endtask

    initial begin
        logic [31:0] vals [8];
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
        vals[2] = 32'h7fff_ffff; vals[3] = 32'h8000_0000;
        vals[4] = 32'hffff_ffff; vals[5] = 32'h1234_5678;
        vals[6] = 32'h0000_8000; vals[7] = 32'hffff_8000;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", cr_o, 32'h0);
        check_read_port("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", cr_o, 32'h0);

        // R10: full load, then every mask value
        do_op("R10", 5, 32'hA5C3_961E, 0, 0, 0, 0, 0, 0, 8'hFF, 0);
        for (int m = 0; m < 256; m++) begin
            do_op("R10", 5, 32'h3C5A_F00F ^ (m * 32'h0101_0101), 0, 0, 0, 0, 0, 0, 8'(m), 0);
        end
        // R3: field numbering through the read port
        check_read_port("R3");

        // R2: no update while valid is low, even with a move presented
        @(negedge clk);
        op_i = 4'd5; opa_i = ~exp_cr; fmask_i = 8'hFF; valid_i = 1'b0;
        @(negedge clk);
        check("R2", cr_o, exp_cr);
        // R2: idle and reserved codes
        do_op("R2", 0, 32'hFFFF_FFFF, 32'h1, 1, 2, 3, 4, 5, 8'hFF, 1);
        do_op("R2", 7, 32'hFFFF_FFFF, 32'h1, 1, 2, 3, 4, 5, 8'hFF, 1);

        // R4 R5 R6 R7 R8 R9: compares across values, fields and so_i
        for (int op = 1; op <= 4; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [31:0] bv;
                    bv = (op >= 3) ? (vals[j] ^ 32'h5A5A_0000) : vals[j];
                    do_op(op == 1 ? "R5" : op == 2 ? "R6" : op == 3 ? "R7" : "R8",
                          op, vals[i], bv, (i + j + op) % 8, 0, 0, 0, 0, 0, 1'((i ^ j) & 1));
                end
            end
        end
        // R4: specific encoding: signed -1 < 1 gives LT with SO
        do_op("R4", 1, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0, 0, 0, 1);
        check("R4", {28'h0, cr_o[31:28]}, 32'h9);
        // R8: unsigned immediate 0x8000 is 32768, not negative
        do_op("R8", 4, 32'h0000_8000, 32'hFFFF_8000, 7, 0, 0, 0, 0, 0, 0);
        check("R8", {28'h0, cr_o[3:0]}, 32'h2);
        check_read_port("R9");

        // R11: every source/destination pair
        do_op("R10", 5, 32'h0123_4567, 0, 0, 0, 0, 0, 0, 8'hFF, 0);
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 8; d++) begin
                do_op("R11", 6, 0, 0, d, s, 0, 0, 0, 0, 0);
            end
            do_op("R10", 5, 32'h89AB_CDEF ^ (s * 32'h1111_1111), 0, 0, 0, 0, 0, 0, 8'hFF, 0);
        end

        // R12 R13: every function, every target, sources overlapping target
        do_op("R10", 5, 32'h6A3F_0C95, 0, 0, 0, 0, 0, 0, 8'hFF, 0);
        for (int f = 8; f < 16; f++) begin
            for (int t = 0; t < 32; t++) begin
                for (int a = 0; a < 32; a++) begin
                    do_op("R12", f, 0, 0, 0, 0, t, a, (a * 7 + t) % 32, 0, 0);
                end
            end
        end
        check_read_port("R13");

        // R14: value presented but update lands only after the edge
        @(negedge clk);
        valid_i = 1'b1; op_i = 4'd5; opa_i = 32'hDEAD_BEEF; fmask_i = 8'hFF;
        #1;
        check("R14", cr_o, exp_cr);
        exp_cr = 32'hDEAD_BEEF;
        @(negedge clk);
        valid_i = 1'b0;
        check("R14", cr_o, exp_cr);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule